// File: doc/BRIEF.md
# VLIW Packet Issue Legality Checker

This block judges one candidate VLIW packet of up to `NSLOT` instruction slots. Each slot carries a valid bit, a 2-bit group code and a 4-bit operation class. The block decides whether the packet can issue in a single cycle under fixed unit-capacity rules. It gives each valid slot a unit index inside its group, and it lists the slots in the order a legal packet is emitted: integer and float/media units interleaved by index (I0, F0, I1, F1, ...), then the branch units.

The legality decision is combinational. The caller pulses `in_stb` with a packet on the inputs. In the next cycle `out_vld` is high and the registered verdict is on the outputs, where it stays until the next strobe. Inside one group the used units are always contiguous from unit 0. A slot that is tied to unit 0 takes it, and flexible slots fill the units above it in ascending slot order. A control instruction must travel alone.

Top module: `vliw_issue_chk`

## Requirements
- R1: After reset `out_vld`, `pkt_ok`, `grp_ok`, `slot_unit` and `ord_vld` are all zero. `out_vld` is high in exactly the cycle after each cycle with `in_stb` high. All other outputs load only on a strobe and hold otherwise.
- R2: Slots with `in_vld` low are ignored whatever their group and class. An empty packet gives all four `grp_ok` bits set, `pkt_ok` high and no `ord_vld` bit set.
- R3: Group code 0 is integer. In that group classes 0 (ALU), 1 (multiply), 2 (divide) and 3 (load) are flexible. Classes 4 (store), 5 (register move) and 6 (jump-and-link) are tied to unit 0. Classes 7 to 15 are illegal. `grp_ok[0]` requires at most one tied slot, at most `NINT` members and no illegal class.
- R4: Integer legality also requires at most `NLOAD` loads, at most one store, and never a load and a store together.
- R5: Group code 1 is float/media. The class is not examined, and `grp_ok[1]` requires at most `NFM` members.
- R6: Group code 2 is branch. Class 7 (jump, branch or condition-code op) is flexible, class 8 (call) is tied to unit 0, and any other class is illegal. `grp_ok[2]` requires at most `NBR` members, at most one tied slot and no illegal class.
- R7: In a legal group a tied slot gets unit 0. Flexible slots get consecutive units in ascending slot order, starting at 1 if a tied slot is present and at 0 if not.
- R8: Group code 3 is control. A control slot that is the only valid slot is legal with unit 0. A control slot together with any other valid slot clears `grp_ok[3]`, clears the bit of every other group that has a member, and clears `pkt_ok`.
- R9: `pkt_ok` is the AND of the four `grp_ok` bits. `slot_unit` is 0 for invalid slots and for slots whose group is illegal.
- R10: Emission positions are built as follows. For k = 0 up to max(NINT,NFM)-1, position I_k is listed if k < NINT and then F_k if k < NFM. After these come B_0 to B_(NBR-1). With the defaults this gives I0, F0, I1, F1, B0, B1 at positions 0 to 5. When `pkt_ok` is high, `ord_vld[p]`/`ord_slot[p]` name the slot on that unit, and a lone control slot is placed at position 0. When `pkt_ok` is low, no `ord_vld` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_stb | input | 1 | Packet present; capture verdict |
| in_vld | input | NSLOT | Per-slot valid |
| in_grp | input | 2*NSLOT | Per-slot group code |
| in_cls | input | 4*NSLOT | Per-slot operation class |
| out_vld | output | 1 | Verdict registered this cycle |
| grp_ok | output | 4 | Per-group legality (integer, float/media, branch, control) |
| pkt_ok | output | 1 | Whole packet legal |
| slot_unit | output | UW*NSLOT | Unit index per slot |
| ord_vld | output | NPOS | Emission position occupied |
| ord_slot | output | SW*NPOS | Slot index at each emission position |

## Verification
The bench builds the block with its defaults: eight slots, two integer, two float/media and two branch units, and two loads. With eight slots every group can overflow its capacity. Two-unit groups are small enough that random packets often hit the interesting cases: a tied slot plus a flexible slot, two tied slots, and a load beside a store. The six emission positions let a full legal packet, presented with its slots scrambled, check the interleaved order completely.

// File: rtl/vliw_issue_pkg.sv
package vliw_issue_pkg;
  localparam int GRP_W = 2;
  localparam int CLS_W = 4;
  localparam logic [GRP_W-1:0] GRP_INT = 2'd0;
  localparam logic [GRP_W-1:0] GRP_FM  = 2'd1;
  localparam logic [GRP_W-1:0] GRP_BR  = 2'd2;
  localparam logic [GRP_W-1:0] GRP_CTL = 2'd3;
  localparam logic [CLS_W-1:0] CLS_LOAD   = 4'd3;
  localparam logic [CLS_W-1:0] CLS_STORE  = 4'd4;
  localparam logic [CLS_W-1:0] CLS_JMPL   = 4'd6;
  localparam logic [CLS_W-1:0] CLS_BRANCH = 4'd7;
  localparam logic [CLS_W-1:0] CLS_CALL   = 4'd8;
endpackage

// File: rtl/vliw_slot_classify.sv
module vliw_slot_classify
  import vliw_issue_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NLOAD = 2
) (
  input  logic [NSLOT-1:0]            vld,
  input  logic [NSLOT-1:0][GRP_W-1:0] grp,
  input  logic [NSLOT-1:0][CLS_W-1:0] cls,
  output logic [2:0][NSLOT-1:0]       member,
  output logic [2:0][NSLOT-1:0]       pinned,
  output logic [2:0][NSLOT-1:0]       bad,
  output logic                        ldst_fail,
  output logic                        ctl_clash
);
  int n_ld, n_st, n_ctl, n_vld;

  always_comb begin
    member = '0;
    pinned = '0;
    bad    = '0;
    n_ld = 0; n_st = 0; n_ctl = 0; n_vld = 0;
    for (int s = 0; s < NSLOT; s++) begin
      if (vld[s]) begin
        n_vld++;
        unique case (grp[s])
          GRP_INT: begin
            member[0][s] = 1'b1;
            pinned[0][s] = (cls[s] >= CLS_STORE) && (cls[s] <= CLS_JMPL);
            bad[0][s]    = (cls[s] > CLS_JMPL);
            if (cls[s] == CLS_LOAD)  n_ld++;
            if (cls[s] == CLS_STORE) n_st++;
          end
          GRP_FM: member[1][s] = 1'b1;
          GRP_BR: begin
            member[2][s] = 1'b1;
            pinned[2][s] = (cls[s] == CLS_CALL);
            bad[2][s]    = (cls[s] != CLS_CALL) && (cls[s] != CLS_BRANCH);
          end
          default: n_ctl++;
        endcase
      end
    end
    ldst_fail = (n_ld > NLOAD) || (n_st > 1) || ((n_ld > 0) && (n_st > 0));
    ctl_clash = (n_ctl > 0) && (n_vld > 1);
  end
endmodule

// File: rtl/vliw_unit_alloc.sv
module vliw_unit_alloc #(
  parameter int NSLOT = 8,
  parameter int NUNIT = 2,
  parameter int UW    = 1
) (
  input  logic [NSLOT-1:0]         member,
  input  logic [NSLOT-1:0]         pinned,
  input  logic [NSLOT-1:0]         bad,
  input  logic                     force_fail,
  output logic                     grp_ok,
  output logic [NSLOT-1:0][UW-1:0] unit
);
  int n_mem, n_pin, rank;
  logic any_bad;

  always_comb begin
    n_mem = 0;
    n_pin = 0;
    any_bad = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (member[s]) begin
        n_mem++;
        if (pinned[s]) n_pin++;
        if (bad[s]) any_bad = 1'b1;
      end
    end
    grp_ok = !any_bad && !force_fail && (n_pin <= 1) && (n_mem <= NUNIT);
    rank = (n_pin != 0) ? 1 : 0;
    unit = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (grp_ok && member[s] && !pinned[s]) begin
        unit[s] = UW'(rank);
        rank++;
      end
    end
  end
endmodule

// File: rtl/vliw_pkt_order.sv
module vliw_pkt_order
  import vliw_issue_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NINT  = 2,
  parameter int NFM   = 2,
  parameter int NBR   = 2,
  parameter int UW    = 1,
  parameter int SW    = 3,
  parameter int NPOS  = 6
) (
  input  logic                        pkt_ok,
  input  logic [NSLOT-1:0]            vld,
  input  logic [NSLOT-1:0][GRP_W-1:0] grp,
  input  logic [NSLOT-1:0][UW-1:0]    unit,
  output logic [NPOS-1:0]             ord_vld,
  output logic [NPOS-1:0][SW-1:0]     ord_slot
);
  localparam int MAXIF = (NINT > NFM) ? NINT : NFM;

  // Position code: group * 256 + unit index.
  function automatic int pos_code(input int p);
    int q = 0;
    for (int k = 0; k < MAXIF; k++) begin
      if (k < NINT) begin
        if (q == p) return k;
        q++;
      end
      if (k < NFM) begin
        if (q == p) return 256 + k;
        q++;
      end
    end
    for (int k = 0; k < NBR; k++) begin
      if (q == p) return 512 + k;
      q++;
    end
    return 0;
  endfunction

  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    localparam int PC = pos_code(p);
    localparam logic [GRP_W-1:0] PG = GRP_W'(PC / 256);
    localparam logic [UW-1:0]    PU = UW'(PC % 256);
    always_comb begin
      ord_vld[p]  = 1'b0;
      ord_slot[p] = '0;
      for (int s = 0; s < NSLOT; s++) begin
        if (pkt_ok && vld[s] &&
            ((grp[s] == PG && unit[s] == PU) || (p == 0 && grp[s] == GRP_CTL))) begin
          ord_vld[p]  = 1'b1;
          ord_slot[p] = SW'(s);
        end
      end
    end
  end
endmodule

// File: rtl/vliw_issue_chk.sv
module vliw_issue_chk
  import vliw_issue_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NINT  = 2,
  parameter int NFM   = 2,
  parameter int NBR   = 2,
  parameter int NLOAD = 2,
  localparam int MAXU = (NINT > NFM) ? ((NINT > NBR) ? NINT : NBR) : ((NFM > NBR) ? NFM : NBR),
  localparam int UW   = (MAXU > 1) ? $clog2(MAXU) : 1,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int NPOS = NINT + NFM + NBR
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_stb,
  input  logic [NSLOT-1:0]            in_vld,
  input  logic [NSLOT-1:0][GRP_W-1:0] in_grp,
  input  logic [NSLOT-1:0][CLS_W-1:0] in_cls,
  output logic                        out_vld,
  output logic [3:0]                  grp_ok,
  output logic                        pkt_ok,
  output logic [NSLOT-1:0][UW-1:0]    slot_unit,
  output logic [NPOS-1:0]             ord_vld,
  output logic [NPOS-1:0][SW-1:0]     ord_slot
);
  logic [2:0][NSLOT-1:0]          member, pinned, bad;
  logic                           ldst_fail, ctl_clash;
  logic [2:0]                     force_fail;
  logic [3:0]                     grp_ok_d;
  logic                           pkt_ok_d;
  logic [2:0][NSLOT-1:0][UW-1:0]  unit_g;
  logic [NSLOT-1:0][UW-1:0]       unit_d;
  logic [NPOS-1:0]                ord_vld_d;
  logic [NPOS-1:0][SW-1:0]        ord_slot_d;

  vliw_slot_classify #(.NSLOT(NSLOT), .NLOAD(NLOAD)) u_cls (
    .vld(in_vld), .grp(in_grp), .cls(in_cls),
    .member(member), .pinned(pinned), .bad(bad),
    .ldst_fail(ldst_fail), .ctl_clash(ctl_clash)
  );

  for (genvar g = 0; g < 3; g++) begin : g_grp
    localparam int NU = (g == 0) ? NINT : ((g == 1) ? NFM : NBR);
    assign force_fail[g] = (ctl_clash && (|member[g])) || ((g == 0) && ldst_fail);
    vliw_unit_alloc #(.NSLOT(NSLOT), .NUNIT(NU), .UW(UW)) u_alloc (
      .member(member[g]), .pinned(pinned[g]), .bad(bad[g]),
      .force_fail(force_fail[g]), .grp_ok(grp_ok_d[g]), .unit(unit_g[g])
    );
  end

  assign grp_ok_d[3] = !ctl_clash;
  assign pkt_ok_d    = &grp_ok_d;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      unit_d[s] = unit_g[0][s] | unit_g[1][s] | unit_g[2][s];
    end
  end

  vliw_pkt_order #(
    .NSLOT(NSLOT), .NINT(NINT), .NFM(NFM), .NBR(NBR),
    .UW(UW), .SW(SW), .NPOS(NPOS)
  ) u_ord (
    .pkt_ok(pkt_ok_d), .vld(in_vld), .grp(in_grp), .unit(unit_d),
    .ord_vld(ord_vld_d), .ord_slot(ord_slot_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      grp_ok    <= '0;
      pkt_ok    <= 1'b0;
      slot_unit <= '0;
      ord_vld   <= '0;
      ord_slot  <= '0;
    end else begin
      out_vld <= in_stb;
      if (in_stb) begin
        grp_ok    <= grp_ok_d;
        pkt_ok    <= pkt_ok_d;
        slot_unit <= unit_d;
        ord_vld   <= ord_vld_d;
        ord_slot  <= ord_slot_d;
      end
    end
  end
endmodule

// File: rtl/vliw_issue_chk_sva.sv
module vliw_issue_chk_sva
  import vliw_issue_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int UW    = 1,
  parameter int NPOS  = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_stb,
  input logic [NSLOT-1:0]            in_vld,
  input logic [NSLOT-1:0][GRP_W-1:0] in_grp,
  input logic [NSLOT-1:0][CLS_W-1:0] in_cls,
  input logic                        out_vld,
  input logic [3:0]                  grp_ok,
  input logic                        pkt_ok,
  input logic [NSLOT-1:0][UW-1:0]    slot_unit,
  input logic [NPOS-1:0]             ord_vld
);
  int n_ld, n_st, n_ctl, n_vld;

  always_comb begin
    n_ld = 0; n_st = 0; n_ctl = 0; n_vld = 0;
    for (int s = 0; s < NSLOT; s++) begin
      if (in_vld[s]) begin
        n_vld++;
        if (in_grp[s] == GRP_CTL) n_ctl++;
        if (in_grp[s] == GRP_INT && in_cls[s] == CLS_LOAD)  n_ld++;
        if (in_grp[s] == GRP_INT && in_cls[s] == CLS_STORE) n_st++;
      end
    end
  end

  assert_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> out_vld);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |=> !out_vld && $stable(pkt_ok) && $stable(grp_ok) && $stable(slot_unit) && $stable(ord_vld));
  assert_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && in_vld == '0) |=> pkt_ok && ord_vld == '0);
  assert_ldst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && n_ld > 0 && n_st > 0) |=> !grp_ok[0]);
  assert_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && n_ctl > 0 && n_vld > 1) |=> !pkt_ok && !grp_ok[3]);
  assert_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> (!pkt_ok || $countones(ord_vld) == $past(n_vld)));
  assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !pkt_ok) |-> ord_vld == '0);
endmodule

bind vliw_issue_chk vliw_issue_chk_sva #(.NSLOT(NSLOT), .UW(UW), .NPOS(NPOS)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_vld(in_vld), .in_grp(in_grp),
  .in_cls(in_cls), .out_vld(out_vld), .grp_ok(grp_ok), .pkt_ok(pkt_ok),
  .slot_unit(slot_unit), .ord_vld(ord_vld)
);

// File: tb/vliw_issue_chk_test.sv
`timescale 1ns/1ps
module vliw_issue_chk_test;
  localparam int NSLOT = 8, NINT = 2, NFM = 2, NBR = 2, NLOAD = 2;
  localparam int MAXU = 2, UW = 1, SW = 3, NPOS = 6;

  logic clk = 1'b0, rst_n = 1'b0, in_stb = 1'b0;
  logic [NSLOT-1:0] in_vld = '0;
  logic [NSLOT-1:0][1:0] in_grp = '0;
  logic [NSLOT-1:0][3:0] in_cls = '0;
  logic out_vld, pkt_ok;
  logic [3:0] grp_ok;
  logic [NSLOT-1:0][UW-1:0] slot_unit;
  logic [NPOS-1:0] ord_vld;
  logic [NPOS-1:0][SW-1:0] ord_slot;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [3:0] e_grp;
  logic e_pkt;
  int e_unit[NSLOT];
  logic e_ovld[NPOS];
  int e_oslot[NPOS];

  vliw_issue_chk uut (
    .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_vld(in_vld), .in_grp(in_grp),
    .in_cls(in_cls), .out_vld(out_vld), .grp_ok(grp_ok), .pkt_ok(pkt_ok),
    .slot_unit(slot_unit), .ord_vld(ord_vld), .ord_slot(ord_slot)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit good, input string req, input string what, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model();
    int n_int = 0, n_fm = 0, n_br = 0, n_ctl = 0, nv = 0;
    int p_int = 0, p_br = 0, nld = 0, nst = 0;
    bit b_int = 0, b_br = 0, clash, ld_bad;
    int r_int, r_br, r_fm, q;
    for (int s = 0; s < NSLOT; s++) begin
      if (!in_vld[s]) continue;
      nv++;
      case (in_grp[s])
        2'd0: begin
          n_int++;
          if (in_cls[s] >= 4 && in_cls[s] <= 6) p_int++;
          if (in_cls[s] > 6) b_int = 1;
          if (in_cls[s] == 3) nld++;
          if (in_cls[s] == 4) nst++;
        end
        2'd1: n_fm++;
        2'd2: begin
          n_br++;
          if (in_cls[s] == 8) p_br++;
          else if (in_cls[s] != 7) b_br = 1;
        end
        default: n_ctl++;
      endcase
    end
    clash  = (n_ctl > 0) && (nv > 1);
    ld_bad = (nld > NLOAD) || (nst > 1) || (nld > 0 && nst > 0);
    e_grp[0] = !b_int && p_int <= 1 && n_int <= NINT && !ld_bad && !(clash && n_int > 0);
    e_grp[1] = n_fm <= NFM && !(clash && n_fm > 0);
    e_grp[2] = !b_br && p_br <= 1 && n_br <= NBR && !(clash && n_br > 0);
    e_grp[3] = !clash;
    e_pkt = &e_grp;
    r_int = (p_int > 0) ? 1 : 0;
    r_br  = (p_br > 0) ? 1 : 0;
    r_fm  = 0;
    for (int s = 0; s < NSLOT; s++) begin
      e_unit[s] = 0;
      if (!in_vld[s]) continue;
      if (in_grp[s] == 2'd0 && e_grp[0] && !(in_cls[s] >= 4 && in_cls[s] <= 6)) begin
        e_unit[s] = r_int; r_int++;
      end
      if (in_grp[s] == 2'd1 && e_grp[1]) begin
        e_unit[s] = r_fm; r_fm++;
      end
      if (in_grp[s] == 2'd2 && e_grp[2] && in_cls[s] != 8) begin
        e_unit[s] = r_br; r_br++;
      end
    end
    q = 0;
    for (int k = 0; k < MAXU; k++) begin
      for (int g = 0; g < 2; g++) begin
        if ((g == 0 && k < NINT) || (g == 1 && k < NFM)) begin
          e_ovld[q] = 0; e_oslot[q] = 0;
          for (int s = 0; s < NSLOT; s++)
            if (e_pkt && in_vld[s] && in_grp[s] == 2'(g) && e_unit[s] == k) begin
              e_ovld[q] = 1; e_oslot[q] = s;
            end
          q++;
        end
      end
    end
    for (int k = 0; k < NBR; k++) begin
      e_ovld[q] = 0; e_oslot[q] = 0;
      for (int s = 0; s < NSLOT; s++)
        if (e_pkt && in_vld[s] && in_grp[s] == 2'd2 && e_unit[s] == k) begin
          e_ovld[q] = 1; e_oslot[q] = s;
        end
      q++;
    end
    for (int s = 0; s < NSLOT; s++)
      if (e_pkt && in_vld[s] && in_grp[s] == 2'd3) begin
        e_ovld[0] = 1; e_oslot[0] = s;
      end
  endtask

  task automatic run(input string req);
    @(negedge clk);
    in_stb = 1'b1;
    model();
    @(negedge clk);
    in_stb = 1'b0;
    chk(out_vld == 1'b1, "R1", {req, " out_vld"}, int'(out_vld), 1);
    for (int g = 0; g < 4; g++)
      chk(grp_ok[g] == e_grp[g], req, $sformatf("grp_ok[%0d]", g), int'(grp_ok[g]), int'(e_grp[g]));
    chk(pkt_ok == e_pkt, req, "pkt_ok", int'(pkt_ok), int'(e_pkt));
    for (int s = 0; s < NSLOT; s++)
      chk(int'(slot_unit[s]) == e_unit[s], req, $sformatf("slot_unit[%0d]", s), int'(slot_unit[s]), e_unit[s]);
    for (int p = 0; p < NPOS; p++) begin
      chk(ord_vld[p] == e_ovld[p], req, $sformatf("ord_vld[%0d]", p), int'(ord_vld[p]), int'(e_ovld[p]));
      if (e_ovld[p])
        chk(int'(ord_slot[p]) == e_oslot[p], req, $sformatf("ord_slot[%0d]", p), int'(ord_slot[p]), e_oslot[p]);
    end
  endtask

  task automatic clr();
    in_vld = '0; in_grp = '0; in_cls = '0;
  endtask

  task automatic put(input int s, input int g, input int c);
    in_vld[s] = 1'b1; in_grp[s] = 2'(g); in_cls[s] = 4'(c);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0 && pkt_ok == 1'b0 && grp_ok == 4'd0, "R1", "reset state", int'({out_vld, pkt_ok, grp_ok}), 0);
    chk(ord_vld == '0 && slot_unit == '0, "R1", "reset vectors", int'(ord_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    clr(); run("R2 empty packet");
    clr(); in_grp = '1; in_cls = '1; run("R2 invalid slots ignored");
    @(negedge clk);
    chk(out_vld == 1'b0, "R1", "out_vld drops without strobe", int'(out_vld), 0);
    chk(pkt_ok == 1'b1, "R1", "pkt_ok held", int'(pkt_ok), 1);

    clr(); put(2, 0, 0); put(5, 0, 1); run("R7 two flexible integer");
    clr(); put(1, 0, 0); put(4, 0, 4); run("R7 tied store after ALU");
    clr(); put(0, 0, 5); put(3, 0, 6); run("R3 two tied integer");
    clr(); put(0, 0, 0); put(1, 0, 2); put(2, 0, 1); run("R3 integer overflow");
    clr(); put(6, 0, 9); run("R3 illegal integer class");
    clr(); put(0, 0, 3); put(7, 0, 3); run("R4 two loads");
    clr(); put(0, 0, 3); put(1, 0, 4); run("R4 load with store");
    clr(); put(2, 0, 4); put(3, 0, 4); run("R4 two stores");
    clr(); put(0, 1, 4); put(1, 1, 15); put(2, 1, 0); run("R5 float overflow");
    clr(); put(0, 1, 9); put(5, 1, 3); run("R5 class not examined");
    clr(); put(3, 2, 7); put(4, 2, 8); run("R6 call and branch");
    clr(); put(3, 2, 8); put(4, 2, 8); run("R6 two calls");
    clr(); put(1, 2, 3); run("R6 illegal branch class");
    clr(); put(5, 3, 2); run("R8 lone control");
    clr(); put(5, 3, 2); put(0, 0, 0); put(1, 1, 0); run("R8 control with others");
    clr(); put(7, 2, 7); put(6, 1, 0); put(5, 0, 0); put(4, 2, 8); put(2, 1, 1); put(0, 0, 4);
    run("R10 full packet scrambled");
    clr(); put(0, 0, 0); put(1, 0, 0); put(2, 0, 0); put(3, 1, 0); run("R9 partial illegal");

    for (int n = 0; n < 3000; n++) begin
      clr();
      for (int s = 0; s < NSLOT; s++) begin
        int r = $urandom_range(0, 15);
        int g = (r < 6) ? 0 : (r < 11) ? 1 : (r < 15) ? 2 : 3;
        int c = (g == 0) ? $urandom_range(0, 7) :
                (g == 2) ? (($urandom_range(0, 7) == 0) ? $urandom_range(0, 15) : $urandom_range(7, 8)) :
                $urandom_range(0, 15);
        if ($urandom_range(0, 2) == 0) put(s, g, c);
      end
      run("R7 R9 R10 random");
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule